// File: doc/BRIEF.md
# Flash Boot Loader Sequencer

This block copies a configuration image from a serial SPI flash into a downstream device that accepts one byte at a time. A run starts by itself when reset is released, or later on a one-cycle start pulse while the block is idle. Each run first reads a four-byte signature at a fixed flash location. A missing signature means the flash is blank or damaged, so the block stops with an error and does not begin a boot.

When the signature matches, the block opens a second read at the image location. It forwards the raw bytes in flash order, each with a one-cycle valid strobe. After each byte it waits for the target's ready input before it fetches the next one. The stream ends with done when the target reports that configuration is complete. If the target never reports completion, the stream ends with an error once a byte cap is reached. SPI runs in mode 0, with the clock at half the system clock rate, and all transfers are MSB first.

Top module: `flashBootSeq`

## Requirements
- R1: While reset is asserted, chip select is high, the SPI clock is low, and cfgValid, busy, done and error are all low.
- R2: A run launches on its own after reset is released and on a start pulse while idle. A start pulse while busy has no effect, so only the two flash reads of the current run take place.
- R3: The first read of a run lowers chip select and sends the command byte 0x03, then the address 0x600000 as three bytes, most significant byte first. SPI mode 0 applies: the clock idles low, MOSI changes on the falling clock and MISO is sampled on the rising clock.
- R4: The four bytes read must equal 0x53, 0x44, 0x42, 0x2D in read order. On any mismatch the run ends with error set, no byte reaches the configuration port and no second read takes place.
- R5: On a match, chip select goes high and then low again, and a second read sends 0x03 followed by the address 0x100000. Chip select stays low for the whole stream.
- R6: Streamed bytes appear on cfgData unchanged and in flash order, each with a cfgValid pulse exactly one cycle long.
- R7: After each byte the SPI clock stays idle until cfgReady is high.
- R8: If cfgDone is high in the cycle when a byte's cfgValid is shown, the run stops after that byte with done set and error clear. This takes priority over the byte cap.
- R9: If cfgDone never rises, the run stops after exactly MAX_LEN bytes (5 MiB by default) with error set.
- R10: busy is high during a run and low after it. done and error are never high together, they hold until the next launch, and chip select is high once the run has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a run when idle |
| spiMiso | input | 1 | Flash serial data out |
| spiSck | output | 1 | SPI clock |
| spiCsN | output | 1 | Flash chip select, active low |
| spiMosi | output | 1 | Flash serial data in |
| cfgReady | input | 1 | Target can take another byte |
| cfgDone | input | 1 | Target reports configuration complete |
| cfgData | output | 8 | Streamed image byte |
| cfgValid | output | 1 | One-cycle strobe for cfgData |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run ended with completion |
| error | output | 1 | Last run failed on signature or byte cap |

## Verification
The assertions check, on every cycle, the rules that hold at any moment. These are: the valid strobe lasts one cycle, the SPI clock toggles only under chip select, chip select is high after an idle cycle, the byte count never passes the cap, and done and error never both assert. Only the bench scenarios can show the rest. That covers the exact header bytes, the byte order of the stream, the rejection of a bad signature, the waits on a held-off ready, and which of done or the cap ends a stream. The bench compares these against a behavioural flash and target model.

// File: rtl/bootPkg.sv
package bootPkg;
  localparam logic [7:0] READ_CMD = 8'h03;

  typedef struct packed {
    logic       xferGo;
    logic       sendHdr;
    logic       appRegion;
    logic [1:0] hdrIdx;
    logic       csLow;
    logic       sigCapture;
    logic       cntClear;
    logic       emit;
  } bootCmdT;
endpackage

// File: rtl/bootData.sv
module bootData
  import bootPkg::*;
#(
  parameter logic [23:0] SIG_ADDR = 24'h600000,
  parameter logic [23:0] APP_ADDR = 24'h100000,
  parameter logic [31:0] SIG_WORD = 32'h5344422D,
  parameter int unsigned MAX_LEN  = 5 * 1024 * 1024,
  parameter int unsigned CNT_W    = $clog2(MAX_LEN + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  bootCmdT    cmd,
  input  logic       spiMiso,
  output logic       spiSck,
  output logic       spiCsN,
  output logic       spiMosi,
  output logic [7:0] cfgData,
  output logic       cfgValid,
  output logic       xferDone,
  output logic       sigMatch,
  output logic       cntAtMax
);
  logic [7:0]       txShift, rxShift, hdrByte, txByte;
  logic [2:0]       bitCnt;
  logic             active;
  logic [31:0]      sigReg;
  logic [CNT_W-1:0] cnt;
  logic [23:0]      baseAddr;

  assign baseAddr = cmd.appRegion ? APP_ADDR : SIG_ADDR;

  always_comb begin
    unique case (cmd.hdrIdx)
      2'd0:    hdrByte = READ_CMD;
      2'd1:    hdrByte = baseAddr[23:16];
      2'd2:    hdrByte = baseAddr[15:8];
      default: hdrByte = baseAddr[7:0];
    endcase
    txByte = cmd.sendHdr ? hdrByte : 8'h00;
  end

  assign spiMosi  = txShift[7];
  assign sigMatch = (sigReg == SIG_WORD);
  assign cntAtMax = (cnt == CNT_W'(MAX_LEN));

  // byte shifter, two system clocks per SPI bit
  always_ff @(posedge clk) begin
    if (!rstN) begin
      active   <= 1'b0;
      spiSck   <= 1'b0;
      bitCnt   <= '0;
      txShift  <= '0;
      rxShift  <= '0;
      xferDone <= 1'b0;
      spiCsN   <= 1'b1;
    end else begin
      xferDone <= 1'b0;
      spiCsN   <= !cmd.csLow;
      if (cmd.xferGo) begin
        active  <= 1'b1;
        txShift <= txByte;
        bitCnt  <= '0;
        spiSck  <= 1'b0;
      end else if (active) begin
        if (!spiSck) begin
          spiSck  <= 1'b1;
          rxShift <= {rxShift[6:0], spiMiso};
        end else begin
          spiSck  <= 1'b0;
          txShift <= {txShift[6:0], 1'b0};
          bitCnt  <= bitCnt + 3'd1;
          if (bitCnt == 3'd7) begin
            active   <= 1'b0;
            xferDone <= 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sigReg   <= '0;
      cnt      <= '0;
      cfgData  <= '0;
      cfgValid <= 1'b0;
    end else begin
      cfgValid <= 1'b0;
      if (cmd.cntClear) begin
        sigReg <= '0;
        cnt    <= '0;
      end
      if (cmd.sigCapture) sigReg <= {sigReg[23:0], rxShift};
      if (cmd.emit) begin
        cfgData  <= rxShift;
        cfgValid <= 1'b1;
        cnt      <= cnt + CNT_W'(1);
      end
    end
  end

  a_r6_valid_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    cfgValid |=> !cfgValid);
  a_r3_sck_under_cs: assert property (@(posedge clk) disable iff (!rstN)
    spiSck |-> !spiCsN);
  a_r9_count_capped: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_W'(MAX_LEN));
endmodule

// File: rtl/bootCtrl.sv
module bootCtrl
  import bootPkg::*;
#(
  parameter bit BOOT_ON_RESET = 1'b1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    cfgReady,
  input  logic    cfgDone,
  input  logic    xferDone,
  input  logic    sigMatch,
  input  logic    cntAtMax,
  output bootCmdT cmd,
  output logic    busy,
  output logic    done,
  output logic    error
);
  typedef enum logic [3:0] {
    IDLE, HDR_GO, HDR_WAIT, RD_GO, RD_WAIT, SIG_CHK, EMIT, NEXT, PAUSE
  } stateT;

  stateT      state;
  logic [1:0] idx;
  logic       appRegion;
  logic       bootPend;
  logic       launch;

  assign launch = (state == IDLE) && (start || bootPend);
  assign busy   = (state != IDLE);

  always_comb begin
    cmd            = '0;
    cmd.hdrIdx     = idx;
    cmd.appRegion  = appRegion;
    cmd.csLow      = !(state inside {IDLE, SIG_CHK});
    cmd.cntClear   = launch;
    cmd.xferGo     = (state == HDR_GO) || (state == RD_GO);
    cmd.sendHdr    = (state == HDR_GO);
    cmd.sigCapture = (state == RD_WAIT) && xferDone && !appRegion;
    cmd.emit       = (state == EMIT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= IDLE;
      idx       <= '0;
      appRegion <= 1'b0;
      bootPend  <= BOOT_ON_RESET;
      done      <= 1'b0;
      error     <= 1'b0;
    end else begin
      unique case (state)
        IDLE: if (launch) begin
          bootPend  <= 1'b0;
          done      <= 1'b0;
          error     <= 1'b0;
          appRegion <= 1'b0;
          idx       <= '0;
          state     <= HDR_GO;
        end
        HDR_GO: state <= HDR_WAIT;
        HDR_WAIT: if (xferDone) begin
          idx   <= idx + 2'd1;
          state <= (idx == 2'd3) ? RD_GO : HDR_GO;
        end
        RD_GO: state <= RD_WAIT;
        RD_WAIT: if (xferDone) begin
          if (appRegion) state <= EMIT;
          else begin
            idx   <= idx + 2'd1;
            state <= (idx == 2'd3) ? SIG_CHK : RD_GO;
          end
        end
        SIG_CHK: if (sigMatch) begin
          appRegion <= 1'b1;
          state     <= HDR_GO;
        end else begin
          error <= 1'b1;
          state <= IDLE;
        end
        EMIT: state <= NEXT;
        NEXT: if (cfgDone) begin
          done  <= 1'b1;
          state <= IDLE;
        end else if (cntAtMax) begin
          error <= 1'b1;
          state <= IDLE;
        end else state <= PAUSE;
        PAUSE: if (cfgReady) state <= RD_GO;
        default: state <= IDLE;
      endcase
    end
  end

  a_r10_status_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(done && error));
  a_r10_status_only_idle: assert property (@(posedge clk) disable iff (!rstN)
    (done || error) |-> !busy);
endmodule

// File: rtl/flashBootSeq.sv
module flashBootSeq
  import bootPkg::*;
#(
  parameter logic [23:0] SIG_ADDR      = 24'h600000,
  parameter logic [23:0] APP_ADDR      = 24'h100000,
  parameter logic [31:0] SIG_WORD      = 32'h5344422D,
  parameter int unsigned MAX_LEN       = 5 * 1024 * 1024,
  parameter bit          BOOT_ON_RESET = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       spiMiso,
  output logic       spiSck,
  output logic       spiCsN,
  output logic       spiMosi,
  input  logic       cfgReady,
  input  logic       cfgDone,
  output logic [7:0] cfgData,
  output logic       cfgValid,
  output logic       busy,
  output logic       done,
  output logic       error
);
  localparam int unsigned CNT_W = $clog2(MAX_LEN + 1);

  bootCmdT cmd;
  logic    xferDone, sigMatch, cntAtMax;

  bootCtrl #(.BOOT_ON_RESET(BOOT_ON_RESET)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .cfgReady(cfgReady),
    .cfgDone(cfgDone), .xferDone(xferDone), .sigMatch(sigMatch),
    .cntAtMax(cntAtMax), .cmd(cmd), .busy(busy), .done(done), .error(error)
  );

  bootData #(
    .SIG_ADDR(SIG_ADDR), .APP_ADDR(APP_ADDR), .SIG_WORD(SIG_WORD),
    .MAX_LEN(MAX_LEN), .CNT_W(CNT_W)
  ) u_data (
    .clk(clk), .rstN(rstN), .cmd(cmd), .spiMiso(spiMiso),
    .spiSck(spiSck), .spiCsN(spiCsN), .spiMosi(spiMosi),
    .cfgData(cfgData), .cfgValid(cfgValid), .xferDone(xferDone),
    .sigMatch(sigMatch), .cntAtMax(cntAtMax)
  );

  a_r10_cs_high_after_idle: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> spiCsN);
  a_r6_valid_within_run: assert property (@(posedge clk) disable iff (!rstN)
    cfgValid |-> !spiCsN);
endmodule

// File: tb/test_flashBootSeq.sv
module test_flashBootSeq;
  localparam int MAXB = 24;
  localparam logic [23:0] SIGA = 24'h600000;
  localparam logic [23:0] APPA = 24'h100000;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic spiMiso = 1'b0, spiSck, spiCsN, spiMosi;
  logic cfgReady = 1'b1, cfgDone = 1'b0, cfgValid, busy, done, error;
  logic [7:0] cfgData;

  always #2 clk = ~clk;

  flashBootSeq #(.MAX_LEN(MAXB)) i_flashBootSeq (
    .clk(clk), .rstN(rstN), .start(start), .spiMiso(spiMiso),
    .spiSck(spiSck), .spiCsN(spiCsN), .spiMosi(spiMosi),
    .cfgReady(cfgReady), .cfgDone(cfgDone), .cfgData(cfgData),
    .cfgValid(cfgValid), .busy(busy), .done(done), .error(error)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  int sigMode = 0;
  int doneAfter = 0, stall = 0, holdCnt = 0, rcvd = 0;
  bit monOn = 0, prevValid = 0;
  int txnCount = 0, bitsIn = 0;
  logic [31:0] hdr = '0;
  logic [31:0] txnHdr [4];
  logic csQ = 1'b1, sckQ = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] flashByte(input logic [23:0] a);
    logic [7:0] sig [4];
    sig[0] = 8'h53; sig[1] = 8'h44; sig[2] = 8'h42; sig[3] = 8'h2D;
    if (sigMode == 1) sig[3] = 8'h2E;
    if (sigMode == 2) begin sig[0] = 8'hFF; sig[1] = 8'hFF; sig[2] = 8'hFF; sig[3] = 8'hFF; end
    if (a >= SIGA && a < SIGA + 4) return sig[a - SIGA];
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
  endfunction

  // behavioural SPI flash, mode 0
  always @(spiCsN or spiSck) begin
    logic [7:0] b;
    int idx;
    if (!spiCsN && csQ) begin
      txnCount++;
      bitsIn = 0;
      hdr = '0;
    end
    if (!spiCsN && spiSck && !sckQ) begin
      if (bitsIn < 32) hdr = {hdr[30:0], spiMosi};
      bitsIn++;
      if (bitsIn == 32 && txnCount >= 1 && txnCount <= 4) txnHdr[txnCount-1] = hdr;
    end
    if (!spiCsN && !spiSck && sckQ && bitsIn >= 32) begin
      idx = bitsIn - 32;
      b = flashByte(hdr[23:0] + 24'(idx / 8));
      spiMiso = b[7 - (idx % 8)];
    end
    csQ = spiCsN;
    sckQ = spiSck;
  end

  // behavioural configuration target and per-cycle comparison
  always @(negedge clk) begin
    if (monOn) begin
      if (cfgValid) begin
        check(!prevValid, "R6 valid one cycle", 32'(prevValid), 0);
        check(cfgData == flashByte(APPA + 24'(rcvd)), "R6 byte order", cfgData, flashByte(APPA + 24'(rcvd)));
        rcvd++;
        if (doneAfter != 0 && rcvd == doneAfter) cfgDone = 1'b1;
        if (stall > 0) begin cfgReady = 1'b0; holdCnt = stall; end
      end else if (holdCnt > 0) begin
        check(spiSck == 1'b0, "R7 no fetch while not ready", 32'(spiSck), 0);
        holdCnt--;
        if (holdCnt == 0) cfgReady = 1'b1;
      end
      if (!busy) check(!(done && error), "R10 exclusive status", {done, error}, 0);
      prevValid = cfgValid;
    end
  end

  task automatic runScenario(input string name, input int sm, input int dn, input int st,
                             input bit useStart, input bit expDone, input int expBytes);
    int cyc;
    sigMode = sm; doneAfter = dn; stall = st; holdCnt = 0; rcvd = 0;
    cfgDone = 1'b0; cfgReady = 1'b1; txnCount = 0; prevValid = 0;
    for (int i = 0; i < 4; i++) txnHdr[i] = '0;
    monOn = 1;
    if (useStart) begin
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
    end else @(negedge clk);
    check(busy == 1'b1, "R2 launch", 32'(busy), 1);
    cyc = 0;
    while (busy && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (cyc == 300 && sm == 0) begin
        start = 1'b1; @(negedge clk); start = 1'b0; cyc++;
      end
    end
    check(cyc < 20000, {"R10 run ends ", name}, cyc, 20000);
    @(negedge clk);
    monOn = 0;
    check(done == expDone, {"R8 done ", name}, 32'(done), 32'(expDone));
    check(error == !expDone, {"R9 error ", name}, 32'(error), 32'(!expDone));
    check(rcvd == expBytes, {"R9 byte count ", name}, rcvd, expBytes);
    check(spiCsN == 1'b1, {"R10 cs idle ", name}, 32'(spiCsN), 1);
    check(txnHdr[0] == 32'h03600000, {"R3 signature read ", name}, txnHdr[0], 32'h03600000);
    if (sm == 0) begin
      check(txnCount == 2, {"R2 R5 transaction count ", name}, txnCount, 2);
      check(txnHdr[1] == 32'h03100000, {"R5 image read ", name}, txnHdr[1], 32'h03100000);
    end else begin
      check(txnCount == 1, {"R4 single read ", name}, txnCount, 1);
      check(rcvd == 0, {"R4 nothing forwarded ", name}, rcvd, 0);
    end
    repeat (5) @(negedge clk);
    check(done == expDone && !busy, {"R10 status held ", name}, {busy, done}, {1'b0, expDone});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(spiCsN == 1'b1, "R1 cs", 32'(spiCsN), 1);
    check(spiSck == 1'b0, "R1 sck", 32'(spiSck), 0);
    check({cfgValid, busy, done, error} == 4'b0, "R1 status", {cfgValid, busy, done, error}, 0);
    rstN = 1'b1;
    runScenario("startup", 0, 10, 0, 0, 1'b1, 10);
    runScenario("bad last sig byte", 1, 10, 0, 1, 1'b0, 0);
    runScenario("stalled target", 0, 7, 5, 1, 1'b1, 7);
    runScenario("no done cap", 0, 0, 0, 1, 1'b0, MAXB);
    runScenario("done after one", 0, 1, 0, 1, 1'b1, 1);
    runScenario("done at cap", 0, MAXB, 2, 1, 1'b1, MAXB);
    runScenario("blank flash", 2, 10, 0, 1, 1'b0, 0);
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 190000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog R10 actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule